// File: doc/BRIEF.md
# Motor Bridge Enable and Thermal Fault Supervisor

This block decides, once per system clock, whether the power bridge of a two-phase stepper driver may be driven or has to be left floating. It watches an external enable pin, a control-supply undervoltage flag and an over-temperature flag whose hysteresis is applied upstream. All three arrive asynchronously and are resynchronized. A static strap selects which input mode the rest of the driver runs in, and that mode selects the recovery rule after a thermal trip.

In parallel input mode a thermal trip clears itself: the bridge comes back as soon as the over-temperature flag drops. Repeated trips and recoveries give hiccup protection against a shorted load. In clock-in input mode the trip is held. The bridge stays off after the die has cooled, and is released only when the enable pin then shows a high, low, high sequence. A status output is high while such a held trip is pending. A reference-enable output follows the synchronized enable pin. A position-reset output tells the step indexer to return home while the control supply is low.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0. After reset, any held thermal trip is gone, and the bridge follows the enable pin and the flags as if no trip had occurred.
- R2: With the synchronized enable low, `bridgeEn` and `refEn` are 0. In clock-in mode (`clockMode`=1), an over-temperature flag seen while enable is low does not start a held trip.
- R3: With enable high, no undervoltage and no over-temperature, `bridgeEn`=1 and `refEn`=1 in both modes.
- R4: While `uvFlag` is 1, `bridgeEn` is 0 and `indexReset` is 1. When `uvFlag` clears with enable high, `bridgeEn` returns to 1 and `indexReset` to 0.
- R5: While `otFlag` is 1, `bridgeEn` is 0 in both modes.
- R6: In parallel mode (`clockMode`=0), `faultLatched` stays 0. `bridgeEn` returns to 1 as soon as `otFlag` clears with enable high.
- R7: In clock-in mode, `otFlag` seen with enable high sets `faultLatched` to 1. `bridgeEn` stays 0 after `otFlag` clears, for as long as enable is held high.
- R8: A held trip is released, with `faultLatched` back to 0 and `bridgeEn` to 1, only after `otFlag` is clear and enable is then seen high, low and high again. Enable pulses made while `otFlag` is still 1 do not count.
- R9: If `otFlag` returns at any point in the release sequence, the sequence starts over. A later low-to-high enable transition that was not preceded by a high level after the flag cleared does not release the trip.
- R10: With two synchronizer stages, each output reflects an input change on the third rising clock edge after that change. The change is not visible after only two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enPin | input | 1 | Asynchronous bridge enable pin, high enables |
| uvFlag | input | 1 | Asynchronous control-supply undervoltage flag |
| otFlag | input | 1 | Asynchronous over-temperature flag, hysteresis already applied |
| clockMode | input | 1 | Static mode strap: 1 clock-in mode (held trip), 0 parallel mode (self-clearing trip) |
| bridgeEn | output | 1 | 1 drives the bridge from the control logic, 0 leaves it floating |
| refEn | output | 1 | Reference and protection circuits enabled |
| faultLatched | output | 1 | A held thermal trip is waiting for its release sequence |
| indexReset | output | 1 | Return the step indexer to its home position |

## Verification
Every output is registered one stage after a two-flop synchronizer. An input change made between edges therefore shows up on the third rising edge after it. The bench drives each stimulus on a falling edge, waits three rising edges and samples on the next falling edge. One directed test samples after two edges and expects the old value, then after three and expects the new one. The release sequence is walked one enable level at a time with a full three-edge wait per step, so each state of the held trip is observed on the outputs before the next change.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Number of asynchronous inputs resynchronized by the input path
  localparam int FLAG_COUNT = 3;
  localparam int IDX_EN = 0;
  localparam int IDX_UV = 1;
  localparam int IDX_OT = 2;

  // Strobes and levels handed from the input path to the control
  typedef struct packed {
    logic enLevel;
    logic enRise;
    logic enFall;
    logic uvLevel;
    logic otLevel;
  } supStrobes_t;

  // Thermal trip holding state (clock-in mode only)
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,  // no held trip
    ST_HOT       = 3'd1,  // trip held, flag still set
    ST_COOL      = 3'd2,  // flag clear, enable not yet seen high
    ST_SEEN_HIGH = 3'd3,  // enable high after cooling, waiting for low
    ST_SEEN_LOW  = 3'd4   // enable low after that high, waiting for high
  } holdState_t;

endpackage

// File: rtl/sup_input_path.sv
module sup_input_path
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FLAG_COUNT-1:0] rawIn,
  output supStrobes_t           strobes
);

  localparam int TOP_STAGE = SYNC_STAGES - 1;

  logic [FLAG_COUNT-1:0] syncOut;
  logic                  enPrev;

  // One synchronizer chain per asynchronous input
  for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
      end
    end
    assign syncOut[g] = chain[TOP_STAGE];
  end

  // Previous synchronized enable level for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enPrev <= 1'b0;
    end else begin
      enPrev <= syncOut[IDX_EN];
    end
  end

  always_comb begin
    strobes.enLevel = syncOut[IDX_EN];
    strobes.enRise  = syncOut[IDX_EN] & ~enPrev;
    strobes.enFall  = ~syncOut[IDX_EN] & enPrev;
    strobes.uvLevel = syncOut[IDX_UV];
    strobes.otLevel = syncOut[IDX_OT];
  end

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clockMode,
  input  supStrobes_t strobes,
  output logic        bridgeEn,
  output logic        refEn,
  output logic        faultLatched,
  output logic        indexReset
);

  holdState_t state;
  holdState_t stateNext;

  // Held-trip sequencing; parallel mode never holds a trip
  always_comb begin
    stateNext = state;
    if (!clockMode) begin
      stateNext = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (strobes.enLevel && strobes.otLevel) stateNext = ST_HOT;
        end
        ST_HOT: begin
          if (!strobes.otLevel) begin
            stateNext = strobes.enLevel ? ST_SEEN_HIGH : ST_COOL;
          end
        end
        ST_COOL: begin
          if (strobes.otLevel)      stateNext = ST_HOT;
          else if (strobes.enLevel) stateNext = ST_SEEN_HIGH;
        end
        ST_SEEN_HIGH: begin
          if (strobes.otLevel)     stateNext = ST_HOT;
          else if (strobes.enFall) stateNext = ST_SEEN_LOW;
        end
        ST_SEEN_LOW: begin
          if (strobes.otLevel)     stateNext = ST_HOT;
          else if (strobes.enRise) stateNext = ST_RUN;
        end
        default: stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      bridgeEn     <= 1'b0;
      refEn        <= 1'b0;
      faultLatched <= 1'b0;
      indexReset   <= 1'b0;
    end else begin
      state        <= stateNext;
      bridgeEn     <= strobes.enLevel & ~strobes.uvLevel & ~strobes.otLevel
                      & (stateNext == ST_RUN);
      refEn        <= strobes.enLevel;
      faultLatched <= (stateNext != ST_RUN);
      indexReset   <= strobes.uvLevel;
    end
  end

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enPin,
  input  logic uvFlag,
  input  logic otFlag,
  input  logic clockMode,
  output logic bridgeEn,
  output logic refEn,
  output logic faultLatched,
  output logic indexReset
);

  supStrobes_t           strobes;
  logic [FLAG_COUNT-1:0] rawIn;

  always_comb begin
    rawIn         = '0;
    rawIn[IDX_EN] = enPin;
    rawIn[IDX_UV] = uvFlag;
    rawIn[IDX_OT] = otFlag;
  end

  sup_input_path #(
    .SYNC_STAGES(SYNC_STAGES)
  ) inPath_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rawIn  (rawIn),
    .strobes(strobes)
  );

  sup_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clockMode   (clockMode),
    .strobes     (strobes),
    .bridgeEn    (bridgeEn),
    .refEn       (refEn),
    .faultLatched(faultLatched),
    .indexReset  (indexReset)
  );

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic clk,
  input logic rst_n,
  input logic clockMode,
  input logic bridgeEn,
  input logic refEn,
  input logic faultLatched,
  input logic indexReset
);

  AST_BRIDGE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bridgeEn |-> refEn);  // R2

  AST_UV_BLOCKS_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    indexReset |-> !bridgeEn);  // R4

  AST_HELD_TRIP_BLOCKS_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    faultLatched |-> !bridgeEn);  // R7

  AST_PARALLEL_NEVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clockMode && !$past(clockMode)) |-> !faultLatched);  // R6

  AST_TRIP_ENTRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultLatched) |-> !bridgeEn);  // R7

  AST_RELEASE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(faultLatched) && clockMode && !indexReset) |-> bridgeEn);  // R8

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!bridgeEn && !refEn && !faultLatched && !indexReset);  // R1
    end
  end

endmodule

bind drv_fault_supervisor sup_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .clockMode   (clockMode),
  .bridgeEn    (bridgeEn),
  .refEn       (refEn),
  .faultLatched(faultLatched),
  .indexReset  (indexReset)
);

// File: tb/drv_fault_supervisor_tb_top.sv
module drv_fault_supervisor_tb_top;

  localparam int SYNC_STAGES = 2;
  localparam int LAT         = SYNC_STAGES + 1;
  localparam int NUM_VEC     = 27;

  // exp = {bridgeEn, refEn, faultLatched, indexReset}
  typedef struct packed {
    logic       mode;
    logic       en;
    logic       uv;
    logic       ot;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NUM_VEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'd2},  // R2 idle
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd3},  // R3 parallel run
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'b0101, 4'd4},  // R4 undervoltage
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd4},  // R4 recovered
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'b0100, 4'd5},  // R5 thermal off
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd6},  // R6 auto recovery
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 4'd2},  // R2 disabled
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'd2},  // R2
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd3},  // R3 clock-in run
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, 4'd2},  // R2 flag while disabled
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd2},  // R2 no hold resulted
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'b0110, 4'd7},  // R7 trip held
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b0110, 4'd7},  // R7 cooled, still held
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b0010, 4'd8},  // R8 low step
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd8},  // R8 released
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'b0110, 4'd7},  // R7 trip again
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0010, 4'd8},  // R8 toggle while hot
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'b0110, 4'd8},  // R8 not released
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b0110, 4'd8},  // R8 cooled high
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b0010, 4'd8},  // R8 low step
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0010, 4'd9},  // R9 flag returns
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b0010, 4'd9},  // R9 cooled while low
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b0110, 4'd9},  // R9 rise is not release
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b0010, 4'd9},  // R9 low step
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd9},  // R9 released
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'b0101, 4'd4},  // R4 clock-in undervoltage
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd4}   // R4 recovered
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enPin = 1'b0;
  logic uvFlag = 1'b0;
  logic otFlag = 1'b0;
  logic clockMode = 1'b0;
  logic bridgeEn, refEn, faultLatched, indexReset;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  drv_fault_supervisor #(.SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enPin       (enPin),
    .uvFlag      (uvFlag),
    .otFlag      (otFlag),
    .clockMode   (clockMode),
    .bridgeEn    (bridgeEn),
    .refEn       (refEn),
    .faultLatched(faultLatched),
    .indexReset  (indexReset)
  );

  task automatic check(input logic [3:0] exp, input int req, input string what);
    logic [3:0] got;
    got = {bridgeEn, refEn, faultLatched, indexReset};
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(4'b0000, 1, "in reset");          // R1
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NUM_VEC; i++) begin
      clockMode = VEC[i].mode;
      enPin     = VEC[i].en;
      uvFlag    = VEC[i].uv;
      otFlag    = VEC[i].ot;
      settle();
      check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // R10: output not yet changed after two edges, changed on the third
    enPin = 1'b0;
    settle();
    check(4'b0000, 2, "disabled before latency test");  // R2
    enPin = 1'b1;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check(4'b0000, 10, "one edge early");   // R10
    @(posedge clk);
    @(negedge clk);
    check(4'b1100, 10, "on third edge");    // R10

    // R1: reset in the middle of a held trip
    otFlag = 1'b1;
    settle();
    check(4'b0110, 7, "held before reset");  // R7
    rst_n  = 1'b0;
    otFlag = 1'b0;
    #1;
    check(4'b0000, 1, "reset asserted");      // R1
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    check(4'b1100, 1, "hold gone after reset");  // R1

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule